// File: doc/BRIEF.md
# Neighbour-Aware Hit Expansion for a Pixel Array

This block sits between the per-channel threshold comparators of a 10x10 pixel detector and the logic that selects channels for conversion. Each frame carries one flag per channel that says the channel crossed the energy threshold. The block turns that set of flags into a readout-request vector. The vector holds every unmasked hit channel and also every channel whose pixel touches a hit pixel. A hit can share charge with the pixels around it, so these neighbours are read out as well. Channels are not wired in pixel order, so adjacency is worked out in pixel space. The result is then carried back to channel space through a pixel-to-channel table.

Beside each request bit the block keeps a second flag. This flag tells a channel that was above threshold apart from one that is read only because it is a neighbour. Two things come in through a small register port: the contents of the table and a per-channel mask that silences noisy channels. Frames enter on a valid/ready handshake. While any request from the previous frame is still waiting, ready stays low. The scanning logic removes requests one channel at a time as it services them. A frame is captured only once the request vector has emptied, so the producer must hold its frame until then.

Top module: `nnx_hit_expand`

## Requirements
- R1: After reset the request and hit-flag vectors are all zero and `in_ready` is 1. The table holds the identity map, so pixel p reads channel p, and no channel is masked.
- R2: On an accepting edge (`in_valid` and `in_ready` both 1), each channel c that has `in_hits[c]`=1, is unmasked and is named by at least one table entry gets both its request bit and its hit-flag bit set.
- R3: Pixel p lies in row p/10 and column p%10, and it uses channel `map[p]`. When a pixel's channel is an accepted hit, the channels of the 8 surrounding pixels, diagonals included, are also requested. A neighbour's hit flag stays 0 unless that neighbour is itself a hit, so a lone interior hit yields 9 requests.
- R4: Adjacency does not wrap across array edges. A corner hit requests 4 channels, a non-corner edge hit requests 6, and a hit on pixel 9 does not request pixel 10.
- R5: A write with `cfg_we`=1 and `cfg_sel`=0 sets `map[cfg_addr]` = `cfg_wdata`. Later frames find neighbours through the new mapping, even when the neighbours sit on channels that are not adjacent.
- R6: A write with `cfg_we`=1 and `cfg_sel`=1 sets the mask bit of channel `cfg_addr` to `cfg_wdata[0]`. A masked channel sets no hit flag and causes no neighbour requests. It can still be requested, with hit flag 0, as the neighbour of an unmasked hit.
- R7: A configuration write is ignored when `cfg_addr` >= 100. A table write is also ignored when `cfg_wdata` >= 100.
- R8: `in_ready` is 1 exactly when the request vector is all zero. Without an accepting edge, no request bit or hit-flag bit ever goes from 0 to 1, and without a service pulse the outputs hold.
- R9: `svc_valid`=1 with `svc_chan` < 100 clears that channel's request bit and hit-flag bit at the edge and leaves every other bit unchanged. A service pulse with `svc_chan` >= 100 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 table entry, 1 mask bit |
| cfg_addr | input | 7 | Pixel index (table) or channel index (mask) |
| cfg_wdata | input | 7 | Channel number for a table write; bit 0 is the mask value |
| in_valid | input | 1 | A frame of hit flags is offered |
| in_ready | output | 1 | Block can take a frame (request vector empty) |
| in_hits | input | 100 | Per-channel above-threshold flags, bit c = channel c |
| svc_valid | input | 1 | Scanner finished servicing a channel |
| svc_chan | input | 7 | Channel that was serviced |
| req_o | output | 100 | Readout-request vector, bit c = channel c |
| hit_o | output | 100 | 1 = channel was a hit, 0 = neighbour-only readout |

## Verification
The bench aims at the pixel-space edges: corner, edge and wrap-around cases. A design that found neighbours by channel index, or that wrapped columns, would request channels outside the array or on the far side of the row. It swaps two table entries so that one hit's neighbours land on distant channels, which catches designs that spread requests in channel order. It checks that a masked channel is silent as a hit but can still be requested as a neighbour, and that out-of-range writes and service pulses disturb nothing. It also holds a second frame while requests are pending, which exposes a design that overwrites an unserviced frame.

// File: rtl/nnx_pkg.sv
package nnx_pkg;
  localparam int unsigned ARR_ROWS = 10;
  localparam int unsigned ARR_COLS = 10;

  typedef enum logic {
    CFG_TABLE = 1'b0,
    CFG_MASK  = 1'b1
  } cfg_target_e;
endpackage

// File: rtl/nnx_cfg_regs.sv
module nnx_cfg_regs
  import nnx_pkg::*;
#(
  parameter int NPIX = 100,
  parameter int IW   = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_sel,
  input  logic [IW-1:0]             cfg_addr,
  input  logic [IW-1:0]             cfg_wdata,
  output logic [NPIX-1:0][IW-1:0]   map_o,
  output logic [NPIX-1:0]           mask_o
);
  localparam logic [IW:0] LIMIT = (IW+1)'(NPIX);

  logic addr_ok, data_ok, tbl_wr, msk_wr;

  assign addr_ok = {1'b0, cfg_addr}  < LIMIT;
  assign data_ok = {1'b0, cfg_wdata} < LIMIT;
  assign tbl_wr  = cfg_we && (cfg_sel == CFG_TABLE) && addr_ok && data_ok;
  assign msk_wr  = cfg_we && (cfg_sel == CFG_MASK)  && addr_ok;

  for (genvar p = 0; p < NPIX; p++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_o[p]  <= IW'(p);
        mask_o[p] <= 1'b0;
      end else begin
        if (tbl_wr && cfg_addr == IW'(p)) map_o[p]  <= cfg_wdata;
        if (msk_wr && cfg_addr == IW'(p)) mask_o[p] <= cfg_wdata[0];
      end
    end
  end
endmodule

// File: rtl/nnx_neigh.sv
module nnx_neigh #(
  parameter int ROWS = 10,
  parameter int COLS = 10,
  localparam int NPIX = ROWS * COLS
) (
  input  logic [NPIX-1:0] pix_hit,
  output logic [NPIX-1:0] pix_req
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [8:0] win;
      for (genvar dr = 0; dr < 3; dr++) begin : g_dr
        for (genvar dc = 0; dc < 3; dc++) begin : g_dc
          localparam int RR = r + dr - 1;
          localparam int CC = c + dc - 1;
          if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
            assign win[dr*3+dc] = pix_hit[RR*COLS+CC];
          end else begin : g_out
            assign win[dr*3+dc] = 1'b0;
          end
        end
      end
      assign pix_req[r*COLS+c] = |win;
    end
  end
endmodule

// File: rtl/nnx_remap.sv
module nnx_remap #(
  parameter int NPIX = 100,
  parameter int IW   = 7
) (
  input  logic [NPIX-1:0][IW-1:0] map_i,
  input  logic [NPIX-1:0]         ch_hit_i,
  output logic [NPIX-1:0]         pix_hit_o,
  input  logic [NPIX-1:0]         pix_req_i,
  output logic [NPIX-1:0]         ch_req_o,
  output logic [NPIX-1:0]         ch_flag_o
);
  for (genvar p = 0; p < NPIX; p++) begin : g_gather
    assign pix_hit_o[p] = ch_hit_i[map_i[p]];
  end

  always_comb begin
    ch_req_o  = '0;
    ch_flag_o = '0;
    for (int p = 0; p < NPIX; p++) begin
      if (pix_req_i[p]) ch_req_o[map_i[p]]  = 1'b1;
      if (pix_hit_o[p]) ch_flag_o[map_i[p]] = 1'b1;
    end
  end
endmodule

// File: rtl/nnx_hit_expand.sv
module nnx_hit_expand
  import nnx_pkg::*;
#(
  parameter int ROWS = ARR_ROWS,
  parameter int COLS = ARR_COLS,
  localparam int NPIX = ROWS * COLS,
  localparam int IW   = $clog2(NPIX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [IW-1:0]   cfg_addr,
  input  logic [IW-1:0]   cfg_wdata,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [NPIX-1:0] in_hits,
  input  logic            svc_valid,
  input  logic [IW-1:0]   svc_chan,
  output logic [NPIX-1:0] req_o,
  output logic [NPIX-1:0] hit_o
);
  logic [NPIX-1:0][IW-1:0] map_w;
  logic [NPIX-1:0] mask_w, eff_ch, pix_hit, pix_req, ch_req, ch_flag;
  logic [NPIX-1:0] req_q, hit_q;
  logic accept, svc_ok;

  nnx_cfg_regs #(.NPIX(NPIX), .IW(IW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .map_o(map_w), .mask_o(mask_w)
  );

  assign eff_ch = in_hits & ~mask_w;

  nnx_remap #(.NPIX(NPIX), .IW(IW)) remap_i (
    .map_i(map_w), .ch_hit_i(eff_ch), .pix_hit_o(pix_hit),
    .pix_req_i(pix_req), .ch_req_o(ch_req), .ch_flag_o(ch_flag)
  );

  nnx_neigh #(.ROWS(ROWS), .COLS(COLS)) neigh_i (
    .pix_hit(pix_hit), .pix_req(pix_req)
  );

  assign in_ready = ~|req_q;
  assign accept   = in_valid && in_ready;
  assign svc_ok   = svc_valid && ({1'b0, svc_chan} < (IW+1)'(NPIX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      hit_q <= '0;
    end else if (accept) begin
      req_q <= ch_req;
      hit_q <= ch_flag;
    end else if (svc_ok) begin
      req_q[svc_chan] <= 1'b0;
      hit_q[svc_chan] <= 1'b0;
    end
  end

  assign req_o = req_q;
  assign hit_o = hit_q;
endmodule

// File: rtl/nnx_hit_expand_chk.sv
module nnx_hit_expand_chk #(
  parameter int NPIX = 100,
  parameter int IW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            svc_valid,
  input logic [IW-1:0]   svc_chan,
  input logic [NPIX-1:0] req_o,
  input logic [NPIX-1:0] hit_o
);
  logic          clr_q;
  logic [IW-1:0] chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      clr_q  <= svc_valid && !(in_valid && in_ready) &&
                ({1'b0, svc_chan} < (IW+1)'(NPIX));
      chan_q <= svc_chan;
    end
  end

  AST_FLAG_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~req_o) == '0);                                          // R2
  AST_TAKE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> req_o == '0);                           // R8
  AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ((req_o & ~$past(req_o)) == '0) &&
                                ((hit_o & ~$past(hit_o)) == '0));      // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !svc_valid) |=> $stable(req_o) && $stable(hit_o)); // R8
  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> !req_o[chan_q] && !hit_o[chan_q]);                      // R9
endmodule

bind nnx_hit_expand nnx_hit_expand_chk #(.NPIX(NPIX), .IW(IW)) chk_i (.*);

// File: tb/nnx_hit_expand_tb_top.sv
`timescale 1ns/1ps
module nnx_hit_expand_tb_top;
  localparam int ROWS = 10;
  localparam int COLS = 10;
  localparam int NPIX = ROWS * COLS;
  localparam int IW   = 7;

  typedef struct packed {
    logic [NPIX-1:0] req;
    logic [NPIX-1:0] hit;
  } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [IW-1:0]   cfg_addr = '0, cfg_wdata = '0;
  logic            in_valid = 1'b0, in_ready;
  logic [NPIX-1:0] in_hits = '0;
  logic            svc_valid = 1'b0;
  logic [IW-1:0]   svc_chan = '0;
  logic [NPIX-1:0] req_o, hit_o;

  nnx_hit_expand dut_i (.*);

  int checks = 0, errors = 0;
  int m_map[NPIX];
  bit m_mask[NPIX];
  exp_t  exp_q[$];
  string tag_q[$];
  bit pend = 1'b0;

  task automatic chk_vec(string tag, string what, logic [NPIX-1:0] act, logic [NPIX-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [NPIX-1:0] bit_at(int c);
    logic [NPIX-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  function automatic exp_t model(logic [NPIX-1:0] hits);
    exp_t e = '0;
    for (int p = 0; p < NPIX; p++) begin
      int c = m_map[p];
      if (hits[c] && !m_mask[c]) begin
        e.hit[c] = 1'b1;
        for (int dr = -1; dr <= 1; dr++) begin
          for (int dc = -1; dc <= 1; dc++) begin
            int r = p / COLS + dr;
            int k = p % COLS + dc;
            if (r >= 0 && r < ROWS && k >= 0 && k < COLS) e.req[m_map[r*COLS+k]] = 1'b1;
          end
        end
      end
    end
    return e;
  endfunction

  // Scoreboard monitor: one negedge after an accepting edge, compare.
  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      string t;
      pend = 1'b0;
      if (exp_q.size() == 0) begin
        chk_int("R8", "unexpected frame capture", 1, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk_vec(t, "request vector", req_o, e.req);
        chk_vec(t, "hit flags", hit_o, e.hit);
      end
    end
    if (rst_n && in_valid && in_ready) pend = 1'b1;
  end

  task automatic cfg_write(bit sel, int addr, int data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = IW'(addr); cfg_wdata = IW'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (addr < NPIX) begin
      if (!sel && data < NPIX) m_map[addr] = data;
      if (sel) m_mask[addr] = data[0];
    end
  endtask

  task automatic send_frame(logic [NPIX-1:0] hits, string tag);
    exp_q.push_back(model(hits));
    tag_q.push_back(tag);
    in_hits = hits; in_valid = 1'b1;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic service(int c);
    svc_valid = 1'b1; svc_chan = IW'(c);
    @(posedge clk); #1;
    svc_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    for (int c = 0; c < NPIX; c++) if (req_o[c]) service(c);
    chk_int(tag, "ready after drain", int'(in_ready), 1);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NPIX-1:0] v, keep;
    for (int p = 0; p < NPIX; p++) begin m_map[p] = p; m_mask[p] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk_vec("R1", "request after reset", req_o, '0);
    chk_vec("R1", "hit flags after reset", hit_o, '0);
    chk_int("R1", "ready after reset", int'(in_ready), 1);

    // R2/R3 interior hit, identity table
    send_frame(bit_at(44), "R3");
    chk_int("R3", "interior count", $countones(req_o), 9);
    chk_vec("R2", "single hit flag", hit_o, bit_at(44));
    drain("R9");

    // R4 corners and edges
    send_frame(bit_at(0), "R4");
    chk_int("R4", "corner 0 count", $countones(req_o), 4);
    drain("R4");
    send_frame(bit_at(99), "R4");
    chk_int("R4", "corner 99 count", $countones(req_o), 4);
    drain("R4");
    send_frame(bit_at(5), "R4");
    chk_int("R4", "edge count", $countones(req_o), 6);
    drain("R4");
    send_frame(bit_at(9), "R4");
    chk_int("R4", "no wrap to pixel 10", int'(req_o[10]), 0);
    chk_int("R4", "below neighbour 19", int'(req_o[19]), 1);
    drain("R4");

    // R2 adjacent hits both flagged
    send_frame(bit_at(44) | bit_at(45), "R2");
    chk_int("R2", "two-hit count", $countones(req_o), 12);
    drain("R2");

    // R8 back-pressure: pending frame, second frame offered but held off
    send_frame(bit_at(22), "R8");
    keep = req_o;
    in_hits = bit_at(77); in_valid = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk_int("R8", "ready while pending", int'(in_ready), 0);
    chk_vec("R8", "request held", req_o, keep);
    in_valid = 1'b0;
    // R9 single service clears only its bit; out-of-range ignored
    service(120);
    chk_vec("R9", "out-of-range service", req_o, keep);
    service(22);
    chk_vec("R9", "service clears one bit", req_o, keep & ~bit_at(22));
    chk_vec("R9", "service clears flag", hit_o, '0);
    drain("R9");

    // R6 mask
    cfg_write(1'b1, 44, 1);
    send_frame(bit_at(44), "R6");
    chk_vec("R6", "masked hit silent", req_o, '0);
    cfg_write(1'b1, 44, 0);
    cfg_write(1'b1, 45, 1);
    send_frame(bit_at(44) | bit_at(45), "R6");
    chk_int("R6", "masked neighbour requested", int'(req_o[45]), 1);
    chk_int("R6", "masked neighbour flag", int'(hit_o[45]), 0);
    drain("R6");
    cfg_write(1'b1, 45, 0);

    // R7 out-of-range writes
    cfg_write(1'b0, 120, 5);
    cfg_write(1'b0, 3, 110);
    cfg_write(1'b1, 105, 1);
    send_frame(bit_at(3), "R7");
    chk_int("R7", "pixel 3 still identity", $countones(req_o), 6);
    drain("R7");

    // R5 remapped table: swap pixels 0 and 55
    cfg_write(1'b0, 0, 55);
    cfg_write(1'b0, 55, 0);
    send_frame(bit_at(55), "R5");
    v = bit_at(55) | bit_at(1) | bit_at(10) | bit_at(11);
    chk_vec("R5", "remapped neighbours", req_o, v);
    drain("R5");

    // empty frame and multi-hit pattern
    send_frame('0, "R2");
    chk_int("R8", "empty frame keeps ready", int'(in_ready), 1);
    send_frame(bit_at(0) | bit_at(33) | bit_at(67) | bit_at(90), "R3");
    drain("R3");

    repeat (3) @(posedge clk);
    #1;
    chk_int("R8", "scoreboard empty", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule